// File: doc/BRIEF.md
# ARP Next-Hop Resolver

This block finds the Ethernet address that a tunnel endpoint must be sent to. On a start pulse it takes a snapshot of the local IPv4 and MAC addresses. It then picks the next hop. The endpoint itself is the next hop when it shares the local network prefix, or when no gateway is configured. Otherwise the gateway is the next hop. The network prefix is given as a CIDR length.

The block then sends an ARP request for the next hop. The request goes out as a reduced Ethernet frame on a 64-bit byte-enabled transmit stream. The frame carries no preamble, no padding and no FCS. The block then watches the receive stream for a matching reply. If no reply arrives within a per-attempt window, measured in milliseconds from a clocks-per-millisecond count, it sends the request again. After the initial request plus ten retransmissions it gives up. It then signals failure with code 0x0002, and a tunnel handshake must not be started. On success it pulses `done`, shows the resolved address on `resolved_mac` and reports code 0x0001.

Top module: `arp_nexthop_resolver`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `tx_valid` are 0, and `status`, `target_ip` and `resolved_mac` are 0.
- R2: On an accepted start, `target_ip` becomes `gateway_ip` only when `gateway_ip` is non-zero and `endpoint_ip` differs from `local_ip` in any of the top `prefix_len` bits (bit 31 downward). Otherwise `target_ip` becomes `endpoint_ip`. A prefix of 0 places every endpoint on the local subnet.
- R3: Each request is 42 bytes in 6 beats, with byte n on lane n%8 (bits 8*(n%8)+7 down to 8*(n%8)) of beat n/8. `tx_keep` is 0xFF on beats 0–4 and 0x03 on the last beat, and `tx_last` marks beat 5. Multi-byte fields are most significant byte first. Bytes 0–5 are FF. Bytes 6–11 are the local MAC. Bytes 12–13 are 08 06. Bytes 14–15 are 00 01. Bytes 16–17 are 08 00. Byte 18 is 06 and byte 19 is 04. Bytes 20–21 are 00 01. Bytes 22–27 are the local MAC. Bytes 28–31 are the local IP. Bytes 32–37 are zero. Bytes 38–41 are the target IP.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, the beat on `tx_data`/`tx_last` is held unchanged into the next cycle.
- R5: While waiting, a received frame is accepted as the reply when all of the following hold: it has at least 6 beats; its last beat has `rx_keep` ≥ 0x03; `rx_error` is 0; bytes 12–13 are 08 06; bytes 20–21 are 00 02; and bytes 28–31 equal `target_ip`. The cycle after its last beat, `done` is 1 for one cycle, `busy` is 0, `status` is 0x0001 and `resolved_mac` holds bytes 22–27.
- R6: A frame with opcode bytes other than 00 02, with a sender IP other than `target_ip`, or with `rx_error` set on its last beat has no effect. `done` stays 0, `busy` stays 1 and `status` stays 0.
- R7: When no reply is accepted, the request is sent again CLKS_PER_MS*TIMEOUT_MS cycles after the previous request's last beat was accepted. `tx_valid` is 0 up to that point and 1 in the following cycle.
- R8: When the window after the 11th request (10 retransmissions) ends with no reply, `fail` is 1 for one cycle, `status` is 0x0002, `busy` is 0, `done` stays 0, and no further request is sent.
- R9: A reply whose last beat arrives in the same cycle the window ends is accepted in preference to a retry or a failure. A reply one cycle later is ignored.
- R10: `start` while `busy` is 1 is ignored, and `target_ip` keeps its value.
- R11: `resolved_mac` changes only in the cycle `done` is 1. A failed resolution leaves the previous address in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a resolution when idle |
| prefix_len | input | 5 | CIDR prefix length of the local subnet (0–31) |
| local_ip | input | 32 | Own IPv4 address |
| local_mac | input | 48 | Own MAC address |
| gateway_ip | input | 32 | Gateway address, 0 when there is no gateway |
| endpoint_ip | input | 32 | Remote tunnel endpoint address |
| tx_valid | output | 1 | Request beat valid |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_data | output | 64 | Request beat data |
| tx_keep | output | 8 | Request byte enables |
| tx_last | output | 1 | Final beat of the request |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | 64 | Receive beat data |
| rx_keep | input | 8 | Receive byte enables |
| rx_last | input | 1 | Final beat of a received frame |
| rx_error | input | 1 | Received frame is bad (valid with rx_last) |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle unreachable pulse |
| status | output | 16 | 0x0001 resolved, 0x0002 unreachable, 0 otherwise |
| target_ip | output | 32 | Next-hop address being resolved |
| resolved_mac | output | 48 | Last resolved hardware address |

## Verification
Two events can fall in the same cycle: acceptance of a matching reply, and the end of a retry window. That window end is either a retransmission or, after the last attempt, the unreachable failure. The bench counts cycles from the accepted last request beat and times the reply's final beat to land exactly on the window's last cycle, once on the first attempt and once on the eleventh. It then judges that `done` rises, `fail` stays low and no further request appears. It also moves the reply one cycle later and checks that it is dropped and the retry goes out instead.

// File: rtl/arp_nexthop_resolver.sv
module arp_nexthop_resolver #(
  parameter int CLKS_PER_MS = 1000,
  parameter int TIMEOUT_MS  = 100,
  parameter int RETRIES     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  prefix_len,
  input  logic [31:0] local_ip,
  input  logic [47:0] local_mac,
  input  logic [31:0] gateway_ip,
  input  logic [31:0] endpoint_ip,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [63:0] tx_data,
  output logic [7:0]  tx_keep,
  output logic        tx_last,
  input  logic        rx_valid,
  input  logic [63:0] rx_data,
  input  logic [7:0]  rx_keep,
  input  logic        rx_last,
  input  logic        rx_error,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic [15:0] status,
  output logic [31:0] target_ip,
  output logic [47:0] resolved_mac
);
  localparam int BEATS  = 6;
  localparam int FBYTES = BEATS * 8;
  localparam int TICK_W = $clog2(CLKS_PER_MS + 1);
  localparam int MS_W   = $clog2(TIMEOUT_MS + 1);
  localparam int TRY_W  = $clog2(RETRIES + 1);
  localparam logic [15:0] ST_OK   = 16'h0001;
  localparam logic [15:0] ST_FAIL = 16'h0002;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;
  state_t st;

  logic [2:0]       beat;
  logic [TICK_W-1:0] tick;
  logic [MS_W-1:0]  ms;
  logic [TRY_W-1:0] tries;
  logic [47:0]      own_mac;
  logic [31:0]      own_ip;

  // next-hop choice
  wire [31:0] pfx_mask  = ~(32'hFFFF_FFFF >> prefix_len);
  wire        in_subnet = ((endpoint_ip ^ local_ip) & pfx_mask) == 32'd0;
  wire        via_gw    = (gateway_ip != 32'd0) && !in_subnet;
  wire [31:0] pick_ip   = via_gw ? gateway_ip : endpoint_ip;

  // request frame, first wire byte at the top of wire_seq
  wire [FBYTES*8-1:0] wire_seq = {48'hFFFF_FFFF_FFFF, own_mac, 16'h0806,
                                  16'h0001, 16'h0800, 8'h06, 8'h04, 16'h0001,
                                  own_mac, own_ip, 48'h0, target_ip, 48'h0};
  logic [FBYTES*8-1:0] frame;
  for (genvar i = 0; i < FBYTES; i++) begin : g_lane
    assign frame[8*i +: 8] = wire_seq[FBYTES*8-1-8*i -: 8];
  end

  assign tx_valid = (st == S_SEND);
  assign tx_last  = (beat == 3'(BEATS - 1));
  assign tx_data  = frame[64*beat +: 64];
  assign tx_keep  = tx_last ? 8'h03 : 8'hFF;
  assign busy     = (st != S_IDLE);

  // receive capture
  logic [2:0]  rx_idx;
  logic [63:0] rb1, rb2, rb3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idx <= '0;
      rb1 <= '0;
      rb2 <= '0;
      rb3 <= '0;
    end else if (rx_valid) begin
      if (rx_idx == 3'd1) rb1 <= rx_data;
      if (rx_idx == 3'd2) rb2 <= rx_data;
      if (rx_idx == 3'd3) rb3 <= rx_data;
      if (rx_last) rx_idx <= '0;
      else if (rx_idx != 3'd7) rx_idx <= rx_idx + 3'd1;
    end
  end

  wire [15:0] r_type = {rb1[39:32], rb1[47:40]};
  wire [15:0] r_op   = {rb2[39:32], rb2[47:40]};
  wire [47:0] r_mac  = {rb2[55:48], rb2[63:56], rb3[7:0], rb3[15:8],
                        rb3[23:16], rb3[31:24]};
  wire [31:0] r_ip   = {rb3[39:32], rb3[47:40], rb3[55:48], rb3[63:56]};
  wire long_enough   = (rx_idx > 3'd5) || (rx_idx == 3'd5 && rx_keep >= 8'h03);
  wire hit = (st == S_WAIT) && rx_valid && rx_last && !rx_error && long_enough &&
             r_type == 16'h0806 && r_op == 16'h0002 && r_ip == target_ip;

  wire tick_end = (tick == TICK_W'(CLKS_PER_MS - 1));
  wire ms_end   = (ms == MS_W'(TIMEOUT_MS - 1));
  wire expired  = (st == S_WAIT) && tick_end && ms_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      beat <= '0;
      tick <= '0;
      ms <= '0;
      tries <= '0;
      own_mac <= '0;
      own_ip <= '0;
      target_ip <= '0;
      resolved_mac <= '0;
      status <= '0;
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          target_ip <= pick_ip;
          own_mac <= local_mac;
          own_ip <= local_ip;
          tries <= '0;
          beat <= '0;
          status <= '0;
          st <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          if (tx_last) begin
            beat <= '0;
            tick <= '0;
            ms <= '0;
            st <= S_WAIT;
          end else begin
            beat <= beat + 3'd1;
          end
        end
        S_WAIT: begin
          if (hit) begin
            resolved_mac <= r_mac;
            status <= ST_OK;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (expired) begin
            if (tries == TRY_W'(RETRIES)) begin
              status <= ST_FAIL;
              fail <= 1'b1;
              st <= S_IDLE;
            end else begin
              tries <= tries + 1'b1;
              st <= S_SEND;
            end
          end else if (tick_end) begin
            tick <= '0;
            ms <= ms + 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arp_nexthop_resolver_chk.sv
module arp_nexthop_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic [7:0]  tx_keep,
  input logic        tx_last,
  input logic        busy,
  input logic        done,
  input logic        fail,
  input logic [15:0] status,
  input logic [31:0] target_ip,
  input logic [47:0] resolved_mac
);
  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_last |-> tx_keep == 8'hFF);
  // R3
  tail_after_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_last |-> $past(tx_valid));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail}));
  // R5
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status == 16'h0001 && !busy && !tx_valid);
  // R8
  fail_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> status == 16'h0002 && !busy && !tx_valid);
  // R11
  mac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(resolved_mac));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(target_ip));
endmodule

bind arp_nexthop_resolver arp_nexthop_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep), .tx_last(tx_last),
  .busy(busy), .done(done), .fail(fail), .status(status),
  .target_ip(target_ip), .resolved_mac(resolved_mac)
);

// File: tb/sim_arp_nexthop_resolver.sv
module sim_arp_nexthop_resolver;
  localparam int CPM = 20;
  localparam int TMS = 2;
  localparam int T   = CPM * TMS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] prefix_len = '0;
  logic [31:0] local_ip = 32'hC0A8_0A05, gateway_ip = '0, endpoint_ip = '0;
  logic [47:0] local_mac = 48'h0211_2233_4455;
  logic tx_valid, tx_ready = 1'b1, tx_last;
  logic [63:0] tx_data;
  logic [7:0] tx_keep;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_error = 1'b0;
  logic [63:0] rx_data = '0;
  logic [7:0] rx_keep = '0;
  logic busy, done, fail;
  logic [15:0] status;
  logic [31:0] target_ip;
  logic [47:0] resolved_mac;

  arp_nexthop_resolver #(.CLKS_PER_MS(CPM), .TIMEOUT_MS(TMS), .RETRIES(10)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .prefix_len(prefix_len),
    .local_ip(local_ip), .local_mac(local_mac), .gateway_ip(gateway_ip),
    .endpoint_ip(endpoint_ip), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_keep(tx_keep), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_keep(rx_keep),
    .rx_last(rx_last), .rx_error(rx_error), .busy(busy), .done(done),
    .fail(fail), .status(status), .target_ip(target_ip),
    .resolved_mac(resolved_mac));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, req_count = 0, cap_n = 0, bi = 0;
  logic [63:0] cap [8];
  logic [7:0] capk [8];
  logic [7:0] lfsr = 8'h5A;
  bit bp_on = 1'b0;
  bit hold_pend = 1'b0;
  logic [63:0] hold_d;
  logic hold_l;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R4",
            "stalled beat changed", tx_data, hold_d);
      hold_pend = tx_valid && !tx_ready;
      hold_d = tx_data;
      hold_l = tx_last;
      if (tx_valid && tx_ready) begin
        if (bi < 8) begin
          cap[bi] = tx_data;
          capk[bi] = tx_keep;
        end
        bi++;
        if (tx_last) begin
          cap_n = bi;
          bi = 0;
          req_count++;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_req(input int n);
    while (req_count < n) step();
  endtask

  function automatic logic [7:0] fld(input logic [63:0] v, input int nbytes, input int k);
    return 8'(v >> (8 * (nbytes - 1 - k)));
  endfunction

  function automatic logic [7:0] req_byte(input int i, input logic [31:0] tgt);
    if (i < 6) return 8'hFF;
    if (i < 12) return fld(64'(local_mac), 6, i - 6);
    case (i)
      12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
      16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
      20: return 8'h00; 21: return 8'h01;
      default: ;
    endcase
    if (i < 28) return fld(64'(local_mac), 6, i - 22);
    if (i < 32) return fld(64'(local_ip), 4, i - 28);
    if (i < 38) return 8'h00;
    return fld(64'(tgt), 4, i - 38);
  endfunction

  function automatic logic [7:0] rep_byte(input int i, input logic [47:0] smac,
                                          input logic [31:0] sip, input logic [15:0] op);
    if (i < 6) return fld(64'(local_mac), 6, i);
    if (i < 12) return fld(64'(smac), 6, i - 6);
    case (i)
      12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
      16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
      20: return op[15:8]; 21: return op[7:0];
      default: ;
    endcase
    if (i < 28) return fld(64'(smac), 6, i - 22);
    if (i < 32) return fld(64'(sip), 4, i - 28);
    if (i < 38) return fld(64'(local_mac), 6, i - 32);
    if (i < 42) return fld(64'(local_ip), 4, i - 38);
    return 8'h00;
  endfunction

  task automatic check_frame(input logic [31:0] tgt);
    bit ok = (cap_n == 6);
    int bad = -1;
    chk(cap_n == 6, "R3", "beat count", 64'(cap_n), 64'd6);
    for (int i = 0; i < 42; i++)
      if (ok && cap[i / 8][8 * (i % 8) +: 8] !== req_byte(i, tgt) && bad < 0) bad = i;
    chk(ok && bad < 0, "R3", "frame byte", 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
    for (int k = 0; k < 5; k++)
      chk(capk[k] == 8'hFF, "R3", "body keep", 64'(capk[k]), 64'hFF);
    chk(capk[5] == 8'h03, "R3", "tail keep", 64'(capk[5]), 64'h03);
  endtask

  task automatic send_reply(input logic [47:0] smac, input logic [31:0] sip,
                            input logic [15:0] op, input bit err);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) rx_data[8 * j +: 8] = rep_byte(8 * k + j, smac, sip, op);
      rx_valid = 1'b1;
      rx_last = (k == 5);
      rx_keep = (k == 5) ? 8'h03 : 8'hFF;
      rx_error = err && (k == 5);
      step();
    end
    rx_valid = 1'b0;
    rx_last = 1'b0;
    rx_error = 1'b0;
  endtask

  task automatic begin_run(input logic [31:0] ep, input logic [31:0] gw, input logic [4:0] p);
    endpoint_ip = ep;
    gateway_ip = gw;
    prefix_len = p;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  function automatic bit same_net(input logic [31:0] a, input logic [31:0] b, input int p);
    for (int i = 0; i < p; i++) if (a[31 - i] != b[31 - i]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    logic [31:0] ep, gw, exp_t;
    logic [47:0] smac, last_mac;
    int base;
    repeat (3) step();
    // R1 reset state
    chk(!busy && !done && !fail && !tx_valid, "R1", "idle flags",
        {busy, done, fail, tx_valid}, 64'd0);
    chk(status == 0 && target_ip == 0 && resolved_mac == 0, "R1", "reset values",
        64'(status) | 64'(target_ip) | 64'(resolved_mac), 64'd0);
    rst_n = 1'b1;
    step();
    chk(!busy && status == 0, "R1", "after release", 64'(busy), 64'd0);
    bp_on = 1'b1;

    // R2 R3 R5 sweep over prefixes, endpoints and gateway presence
    for (int p = 0; p < 32; p++)
      for (int e = 0; e < 2; e++)
        for (int g = 0; g < 2; g++) begin
          if (e == 0) ep = local_ip ^ (32'h1 << (31 - p));
          else ep = (p == 0) ? (local_ip ^ 32'h1) : (local_ip ^ (32'h1 << (32 - p)));
          gw = g ? 32'hC0A8_0A01 : 32'h0;
          exp_t = (gw != 0 && !same_net(ep, local_ip, p)) ? gw : ep;
          smac = 48'h0A00_0000_0000 + 48'(p * 4 + e * 2 + g);
          base = req_count;
          begin_run(ep, gw, 5'(p));
          chk(busy, "R5", "busy after start", 64'(busy), 64'd1);
          wait_req(base + 1);
          chk(target_ip == exp_t, "R2", "next hop", 64'(target_ip), 64'(exp_t));
          check_frame(exp_t);
          send_reply(smac, exp_t, 16'h0002, 1'b0);
          chk(done && !busy && status == 16'h0001, "R5", "accept",
              {done, busy, status}, {1'b1, 1'b0, 16'h0001});
          chk(resolved_mac == smac, "R5", "resolved mac", 64'(resolved_mac), 64'(smac));
          step();
          chk(!done, "R5", "done one cycle", 64'(done), 64'd0);
        end
    last_mac = resolved_mac;

    // R6 R10 ignored replies and start while busy
    prefix_len = 5'd24;
    base = req_count;
    begin_run(32'hC0A8_0A63, 32'h0, 5'd24);
    wait_req(base + 1);
    begin_run(32'h0A00_0001, 32'hC0A8_0A01, 5'd24);
    chk(target_ip == 32'hC0A8_0A63, "R10", "start while busy", 64'(target_ip), 64'hC0A8_0A63);
    send_reply(48'h0B00_0000_0001, 32'hC0A8_0A63, 16'h0001, 1'b0);
    chk(!done && busy && status == 0, "R6", "request opcode", {done, busy}, 64'b01);
    send_reply(48'h0B00_0000_0002, 32'hC0A8_0A64, 16'h0002, 1'b0);
    chk(!done && busy && status == 0, "R6", "wrong sender", {done, busy}, 64'b01);
    send_reply(48'h0B00_0000_0003, 32'hC0A8_0A63, 16'h0002, 1'b1);
    chk(!done && busy && status == 0, "R6", "error frame", {done, busy}, 64'b01);
    chk(resolved_mac == last_mac, "R6", "mac untouched", 64'(resolved_mac), 64'(last_mac));
    send_reply(48'h0B00_0000_0004, 32'hC0A8_0A63, 16'h0002, 1'b0);
    chk(done && resolved_mac == 48'h0B00_0000_0004, "R5", "accept after rejects",
        64'(resolved_mac), 64'h0B00_0000_0004);
    last_mac = resolved_mac;

    // R9 reply one cycle late is ignored, retry proceeds
    base = req_count;
    begin_run(32'hC0A8_0A70, 32'h0, 5'd24);
    wait_req(base + 1);
    repeat (T - 5) step();
    send_reply(48'h0C00_0000_0001, 32'hC0A8_0A70, 16'h0002, 1'b0);
    chk(!done && busy, "R9", "late reply dropped", {done, busy}, 64'b01);
    wait_req(base + 2);
    check_frame(32'hC0A8_0A70);
    send_reply(48'h0C00_0000_0002, 32'hC0A8_0A70, 16'h0002, 1'b0);
    chk(done, "R9", "reply after retry", 64'(done), 64'd1);

    // R9 reply on the window's last cycle wins over retry
    base = req_count;
    begin_run(32'hC0A8_0A71, 32'h0, 5'd24);
    wait_req(base + 1);
    repeat (T - 6) step();
    send_reply(48'h0C00_0000_0003, 32'hC0A8_0A71, 16'h0002, 1'b0);
    chk(done && !fail, "R9", "collision first attempt", {done, fail}, 64'b10);
    repeat (10) step();
    chk(req_count == base + 1 && !tx_valid, "R9", "no retry after win",
        64'(req_count - base), 64'd1);
    last_mac = resolved_mac;

    // R7 R8 no reply: 11 requests, then failure
    base = req_count;
    begin_run(32'h0A01_0203, 32'hC0A8_0A01, 5'd16);
    for (int n = 1; n <= 11; n++) begin
      wait_req(base + n);
      check_frame(32'hC0A8_0A01);
      repeat (T - 1) step();
      chk(!tx_valid && !fail, "R7", "quiet during window", {tx_valid, fail}, 64'd0);
      step();
      if (n < 11)
        chk(tx_valid, "R7", "retransmit at window end", 64'(tx_valid), 64'd1);
      else begin
        chk(fail && !done && !busy && status == 16'h0002, "R8", "unreachable",
            {fail, done, busy, status}, {1'b1, 1'b0, 1'b0, 16'h0002});
        chk(resolved_mac == last_mac, "R11", "mac kept after failure",
            64'(resolved_mac), 64'(last_mac));
      end
    end
    repeat (T + 10) step();
    chk(req_count == base + 11 && !fail, "R8", "no request after failure",
        64'(req_count - base), 64'd11);

    // R9 reply on the final window's last cycle wins over failure
    base = req_count;
    begin_run(32'hC0A8_0A72, 32'h0, 5'd24);
    for (int n = 1; n <= 11; n++) wait_req(base + n);
    repeat (T - 6) step();
    send_reply(48'h0D00_0000_0001, 32'hC0A8_0A72, 16'h0002, 1'b0);
    chk(done && !fail && status == 16'h0001, "R9", "collision final attempt",
        {done, fail, status}, {1'b1, 1'b0, 16'h0001});
    chk(resolved_mac == 48'h0D00_0000_0001, "R11", "mac updated on done",
        64'(resolved_mac), 64'h0D00_0000_0001);
    repeat (T + 5) step();
    chk(req_count == base + 11, "R9", "no twelfth request", 64'(req_count - base), 64'd11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule